// File: doc/BRIEF.md
# Two-wire serial memory slave

This block is a slave device for a two-wire serial memory bus. It holds 128 bytes of internal storage. SCL and SDA are oversampled by the system clock, and the block pulls SDA low through an open-drain enable. Three static strap pins choose which of eight bus positions the device answers to. A master selects the device with an address byte. In a write it then sends a word address followed by one or more data bytes. In a read it clocks bytes out one after another.

Written data is held in a four-byte page buffer and is not applied to the storage array until the master ends the transfer with a stop condition. The stop starts a write timer that stands in for the nonvolatile programming time. While the timer runs, the device ignores the bus completely. A transfer that ends early, or that is cut short by a fresh start, changes nothing.

Top module: `eep_slave`

## Requirements
- R1: After reset, sda_oe is 0, busy is 0, and every storage location reads as 0x00.
- R2: The line events are defined on the synchronized SCL and SDA. A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. The first byte after a start matches when its bits 7:4 are 1010 and its bits 3:1 equal addr_pins[2:0]. Its bit 0 selects the operation: 1 is read, 0 is write. On a match the slave pulls SDA low (sda_oe=1) for the ninth clock, and sda_oe changes only while SCL is low.
- R3: On an address mismatch, no acknowledge is given for that byte or for any byte after it until the next start. Memory and busy are not affected.
- R4: In a write, the second byte is the word address and it is acknowledged. Its bit 7 is ignored, and bits 6:0 load the address pointer.
- R5: Each data byte is acknowledged. The storage array does not change and busy stays 0 until the stop. A stop that follows at least one data byte writes the buffered bytes and raises busy.
- R6: busy stays high for exactly WRITE_CYCLES clock cycles after a committing stop. During that time the slave acknowledges nothing, not even its own address, and never drives SDA.
- R7: A page is four bytes, aligned so that pointer bits 6:2 stay fixed. After each data byte the low two pointer bits increment and wrap within the page, so a fifth or later byte overwrites an earlier one. Other pages are left untouched.
- R8: A stop that comes after the word address but before any data byte writes nothing. A start that comes before the stop discards the buffered bytes. In both cases busy stays 0.
- R9: A read shifts out the byte at the pointer, MSB first, and then increments the pointer, wrapping from 127 to 0. It continues while the master acknowledges (SDA low on the ninth clock). After a master no-acknowledge the slave releases SDA.
- R10: A write of only a word address, followed by a repeated start and a read address byte, begins the read at that word address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line, including own pull-down) |
| addr_pins | input | 3 | Static strap selecting the bus position |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Write timer running, bus ignored |

## Verification
The committing stop starts the write timer. A start seen while the timer runs must lose to it: the two arrive close together when the master sends its own address straight after a write. The bench does exactly that. It expects no acknowledge, expects busy to stay high, and expects the measured busy run to equal WRITE_CYCLES. A second coincidence is a data byte landing on the last lane of a page. There the buffer store and the pointer wrap happen in the same cycle. A six-byte page write starting on lane 2 provokes it, and a read back of the whole page judges it.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;
  localparam int PAGE_W = 2;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANES  = 1 << PAGE_W;
  localparam int CODE_W = 4;
  localparam int PIN_W  = DATA_W - CODE_W - 1;

  typedef logic [ADDR_W-1:0]        addr_t;
  typedef logic [DATA_W-1:0]        data_t;
  typedef logic [PAGE_W-1:0]        lane_t;
  typedef logic [ADDR_W-PAGE_W-1:0] page_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_WADDR, ST_WDATA, ST_RDATA, ST_RACK, ST_SKIP
  } state_e;

  // Selector byte: type code in the top nibble, strap in the next bits.
  function automatic logic dev_match(data_t b, logic [CODE_W-1:0] code,
                                     logic [PIN_W-1:0] pins);
    return (b[DATA_W-1 -: CODE_W] == code) &&
           (b[DATA_W-CODE_W-1 -: PIN_W] == pins);
  endfunction

  // Next write position: page bits kept, lane bits wrap.
  function automatic addr_t page_next(addr_t a);
    return {a[ADDR_W-1:PAGE_W], lane_t'(a[PAGE_W-1:0] + lane_t'(1))};
  endfunction

  // Next read position: whole pointer wraps.
  function automatic addr_t seq_next(addr_t a);
    return a + addr_t'(1);
  endfunction

  // Word address byte: top bit discarded.
  function automatic addr_t word_to_addr(data_t b);
    return b[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [1:0] raw;
  logic [1:0] sync_out;
  logic [1:0] last;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '1;
      else        pipe <= {pipe[STAGES-2:0], raw[g]};
    end
    assign sync_out[g] = pipe[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= '1;
    else        last <= sync_out;
  end

  assign scl_s     = sync_out[1];
  assign sda_s     = sync_out[0];
  assign scl_rise  = scl_s & ~last[1];
  assign scl_fall  = ~scl_s & last[1];
  assign start_det = scl_s & last[1] & last[0] & ~sda_s;
  assign stop_det  = scl_s & last[1] & ~last[0] & sda_s;
endmodule

// File: rtl/eep_store.sv
module eep_store
  import eep_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  we,
  input  lane_t wlane,
  input  data_t wdata,
  input  logic  commit,
  input  page_t cpage,
  input  addr_t raddr,
  output data_t rdata,
  output logic  pending
);
  data_t            mem  [DEPTH];
  data_t            hold [LANES];
  logic [LANES-1:0] valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             valid <= '0;
    else if (clr || commit) valid <= '0;
    else if (we)            valid[wlane] <= 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       hold[l] <= '0;
      else if (we && wlane == lane_t'(l)) hold[l] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (commit) begin
      for (int l = 0; l < LANES; l++)
        if (valid[l]) mem[{cpage, lane_t'(l)}] <= hold[l];
    end
  end

  assign rdata   = mem[raddr];
  assign pending = |valid;
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
  import eep_pkg::*;
#(
  parameter logic [CODE_W-1:0] DEV_CODE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             busy,
  input  logic [PIN_W-1:0] pins,
  input  data_t            rdata,
  output logic             sda_oe,
  output addr_t            ptr,
  output logic             buf_clr,
  output logic             buf_we,
  output lane_t            buf_lane,
  output data_t            buf_data,
  output logic             in_wdata,
  output logic             dev_nack,
  output logic             tx_load
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  state_e           state;
  logic [CNT_W-1:0] bitcnt;
  data_t            shreg;
  data_t            txreg;
  logic             ack_ph;
  logic             rd_pend;
  logic             mack;

  logic start_ok, rx_state, byte_evt, ack_end, dev_hit, rx_bit;

  assign start_ok = start_det & ~busy;
  assign rx_state = state inside {ST_DEV, ST_WADDR, ST_WDATA};
  assign byte_evt = rx_state & ~ack_ph & scl_fall & (bitcnt == FULL);
  assign ack_end  = rx_state & ack_ph & scl_fall;
  assign rx_bit   = rx_state & ~ack_ph & scl_rise & (bitcnt != FULL);
  assign dev_hit  = dev_match(shreg, DEV_CODE, pins);
  assign dev_nack = byte_evt & (state == ST_DEV) & ~dev_hit;
  assign buf_we   = byte_evt & (state == ST_WDATA);
  assign buf_lane = ptr[PAGE_W-1:0];
  assign buf_data = shreg;
  assign buf_clr  = start_ok;
  assign in_wdata = (state == ST_WDATA);
  assign tx_load  = (ack_end & rd_pend) |
                    ((state == ST_RACK) & scl_fall & ~mack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      txreg   <= '0;
      ack_ph  <= 1'b0;
      rd_pend <= 1'b0;
      mack    <= 1'b1;
      sda_oe  <= 1'b0;
      ptr     <= '0;
    end else if (start_ok) begin
      state   <= ST_DEV;
      bitcnt  <= '0;
      ack_ph  <= 1'b0;
      rd_pend <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (stop_det) begin
      state   <= ST_IDLE;
      ack_ph  <= 1'b0;
      rd_pend <= 1'b0;
      sda_oe  <= 1'b0;
    end else if (tx_load) begin
      state   <= ST_RDATA;
      txreg   <= rdata;
      sda_oe  <= ~rdata[DATA_W-1];
      ptr     <= seq_next(ptr);
      bitcnt  <= '0;
      ack_ph  <= 1'b0;
      rd_pend <= 1'b0;
    end else if (ack_end) begin
      ack_ph <= 1'b0;
      sda_oe <= 1'b0;
      bitcnt <= '0;
    end else if (byte_evt) begin
      bitcnt <= '0;
      case (state)
        ST_DEV: begin
          if (dev_hit) begin
            ack_ph  <= 1'b1;
            sda_oe  <= 1'b1;
            rd_pend <= shreg[0];
            if (!shreg[0]) state <= ST_WADDR;
          end else begin
            state <= ST_SKIP;
          end
        end
        ST_WADDR: begin
          ptr    <= word_to_addr(shreg);
          ack_ph <= 1'b1;
          sda_oe <= 1'b1;
          state  <= ST_WDATA;
        end
        default: begin
          ptr    <= page_next(ptr);
          ack_ph <= 1'b1;
          sda_oe <= 1'b1;
        end
      endcase
    end else if (rx_bit) begin
      shreg  <= {shreg[DATA_W-2:0], sda_s};
      bitcnt <= bitcnt + CNT_W'(1);
    end else if (state == ST_RDATA && scl_fall) begin
      if (bitcnt == LAST) begin
        sda_oe <= 1'b0;
        state  <= ST_RACK;
        bitcnt <= '0;
      end else begin
        txreg  <= {txreg[DATA_W-2:0], 1'b0};
        sda_oe <= ~txreg[DATA_W-2];
        bitcnt <= bitcnt + CNT_W'(1);
      end
    end else if (state == ST_RACK && scl_rise) begin
      mack <= sda_s;
    end else if (state == ST_RACK && scl_fall) begin
      state <= ST_SKIP;
    end
  end
endmodule

// File: rtl/eep_slave.sv
module eep_slave
  import eep_pkg::*;
#(
  parameter int                WRITE_CYCLES = 1000,
  parameter logic [CODE_W-1:0] DEV_CODE     = 4'b1010,
  parameter int                SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [PIN_W-1:0] addr_pins,
  output logic             sda_oe,
  output logic             busy
);
  logic  scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic  buf_clr, wr_store, in_wdata, dev_nack, tx_load;
  logic  pending, commit;
  lane_t buf_lane;
  data_t buf_data, rdata;
  addr_t ptr;

  eep_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eep_ctrl #(.DEV_CODE(DEV_CODE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det), .busy(busy),
    .pins(addr_pins), .rdata(rdata), .sda_oe(sda_oe), .ptr(ptr),
    .buf_clr(buf_clr), .buf_we(wr_store), .buf_lane(buf_lane),
    .buf_data(buf_data), .in_wdata(in_wdata), .dev_nack(dev_nack),
    .tx_load(tx_load)
  );

  // Commit only when a stop closes a write that carried data.
  assign commit = stop_det & in_wdata & pending;

  eep_store u_store (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(wr_store),
    .wlane(buf_lane), .wdata(buf_data), .commit(commit),
    .cpage(ptr[ADDR_W-1:PAGE_W]), .raddr(ptr), .rdata(rdata),
    .pending(pending)
  );

  eep_wtimer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(commit), .busy(busy)
  );
endmodule

// File: rtl/eep_slave_chk.sv
module eep_slave_chk
  import eep_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  sda_oe,
  input logic  busy,
  input logic  scl_s,
  input logic  stop_det,
  input logic  dev_nack,
  input logic  wr_store,
  input logic  tx_load,
  input addr_t ptr
);
  assert_silent_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  assert_commit_at_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  assert_oe_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  assert_nack_mismatch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_nack |=> !sda_oe);

  assert_page_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_store |=> (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
                 (ptr[PAGE_W-1:0] == $past(ptr[PAGE_W-1:0]) + lane_t'(1)));

  assert_read_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> ptr == $past(ptr) + addr_t'(1));
endmodule

bind eep_slave eep_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .busy(busy), .scl_s(scl_s),
  .stop_det(stop_det), .dev_nack(dev_nack), .wr_store(wr_store),
  .tx_load(tx_load), .ptr(ptr)
);

// File: tb/eep_slave_tb.sv
module eep_slave_tb;
  localparam int WCYC = 1000;
  localparam int Q    = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       scl = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] pins = 3'b101;
  logic       sda_oe, busy;
  wire        sda_line = m_sda & ~sda_oe;

  eep_slave #(.WRITE_CYCLES(WCYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_pins(pins), .sda_oe(sda_oe), .busy(busy)
  );

  typedef struct { string tag; int val; } item_t;
  item_t exp_q[$];
  item_t obs_q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Monitor: pops expected and observed items in order and compares.
  always @(posedge clk) begin : mon
    item_t e, o;
    if (exp_q.size() > 0 && obs_q.size() > 0) begin
      e = exp_q.pop_front();
      o = obs_q.pop_front();
      n_cmp++;
      if (e.val != o.val) begin
        n_bad++;
        $display("FAIL %s: actual %0h expected %0h", e.tag, o.val, e.val);
      end
    end
  end

  // Busy run length measured at the port.
  int blen = 0, last_blen = 0;
  always @(posedge clk) begin
    if (busy) blen <= blen + 1;
    else if (blen != 0) begin
      last_blen <= blen;
      blen <= 0;
    end
  end

  logic [7:0] wbuf [8];
  logic [7:0] ebuf [8];

  task automatic check(string tag, int act, int expv);
    exp_q.push_back('{tag, expv});
    obs_q.push_back('{tag, act});
  endtask

  task automatic qwait(int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic do_start;
    m_sda = 1'b1; qwait();
    scl = 1'b1;   qwait();
    m_sda = 1'b0; qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic do_stop;
    m_sda = 1'b0; qwait();
    scl = 1'b1;   qwait();
    m_sda = 1'b1; qwait();
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qwait();
      scl = 1'b1;   qwait(2);
      scl = 1'b0;   qwait();
    end
    m_sda = 1'b1; qwait();
    scl = 1'b1;   qwait();
    acked = (sda_line == 1'b0);
    qwait();
    scl = 1'b0;   qwait();
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait();
      scl = 1'b1; qwait();
      b[i] = sda_line;
      qwait();
      scl = 1'b0;
    end
    qwait();
    m_sda = give_ack ? 1'b0 : 1'b1;
    qwait();
    scl = 1'b1; qwait(2);
    scl = 1'b0; qwait();
    m_sda = 1'b1;
  endtask

  task automatic wait_idle;
    while (busy) @(posedge clk);
    #1;
    qwait();
  endtask

  task automatic wr_page(string tag, logic [7:0] a, int n);
    bit ak;
    do_start;
    put_byte(8'hAA, ak); check("R2 write select ack", ak, 1);
    put_byte(a, ak);     check("R4 word address ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      put_byte(wbuf[i], ak); check(tag, ak, 1);
    end
    check("R5 no busy before stop", busy, 0);
    do_stop;
    check("R5 busy after stop", busy, 1);
    wait_idle;
  endtask

  task automatic rd_check(string tag, logic [7:0] a, int n);
    bit ak;
    logic [7:0] rb;
    do_start;
    put_byte(8'hAA, ak); check("R10 select ack", ak, 1);
    put_byte(a, ak);     check("R10 word ack", ak, 1);
    do_start;
    put_byte(8'hAB, ak); check("R10 read select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i != n - 1, rb);
      check(tag, rb, ebuf[i]);
    end
    check("R9 released after nack", sda_oe, 0);
    do_stop;
  endtask

  initial begin : drive
    bit ak;
    logic [7:0] rb;
    repeat (5) @(posedge clk);
    #1;
    check("R1 oe in reset", sda_oe, 0);
    check("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    qwait(2);
    check("R1 oe after reset", sda_oe, 0);

    // R1 / R9: current-address read from reset pointer 0.
    do_start;
    put_byte(8'hAB, ak); check("R2 read select ack", ak, 1);
    get_byte(1'b0, rb);  check("R1 location 0 clear", rb, 0);
    check("R9 released after nack", sda_oe, 0);
    do_stop;

    // R4/R5/R6: byte write with top word bit set, then probe during busy.
    do_start;
    put_byte(8'hAA, ak); check("R2 write select ack", ak, 1);
    put_byte(8'h85, ak); check("R4 word ack", ak, 1);
    put_byte(8'h3C, ak); check("R5 data ack", ak, 1);
    check("R5 no busy before stop", busy, 0);
    do_stop;
    check("R5 busy after stop", busy, 1);
    do_start;
    put_byte(8'hAA, ak); check("R6 no ack while busy", ak, 0);
    do_stop;
    check("R6 still busy", busy, 1);
    wait_idle;
    check("R6 busy length", last_blen, WCYC);
    ebuf[0] = 8'h3C;
    rd_check("R4 msb ignored read", 8'h05, 1);

    // R7 / R9: page at 0, sequential read back.
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr_page("R7 page data ack", 8'h00, 4);
    ebuf[0] = 8'h11; ebuf[1] = 8'h22; ebuf[2] = 8'h33; ebuf[3] = 8'h44;
    rd_check("R9 sequential read", 8'h00, 4);

    // R7: six bytes from lane 2 wrap and overwrite inside page 0x20.
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hA0 + 8'(i);
    wr_page("R7 page data ack", 8'h22, 6);
    ebuf[0] = 8'hA2; ebuf[1] = 8'hA3; ebuf[2] = 8'hA4; ebuf[3] = 8'hA5;
    ebuf[4] = 8'h00;
    rd_check("R7 page wrap", 8'h20, 5);

    // R3: wrong strap, then wrong type code.
    do_start;
    put_byte(8'hA8, ak); check("R3 strap mismatch nack", ak, 0);
    put_byte(8'h05, ak); check("R3 later byte nack", ak, 0);
    put_byte(8'hFF, ak); check("R3 later byte nack", ak, 0);
    do_stop;
    check("R3 no busy", busy, 0);
    do_start;
    put_byte(8'h2A, ak); check("R3 code mismatch nack", ak, 0);
    do_stop;
    ebuf[0] = 8'h3C;
    rd_check("R3 memory untouched", 8'h05, 1);

    // R8: stop with no data, and data cut off by a repeated start.
    do_start;
    put_byte(8'hAA, ak); check("R8 select ack", ak, 1);
    put_byte(8'h30, ak); check("R8 word ack", ak, 1);
    do_stop;
    check("R8 no busy after empty write", busy, 0);
    do_start;
    put_byte(8'hAA, ak); check("R8 select ack", ak, 1);
    put_byte(8'h31, ak); check("R8 word ack", ak, 1);
    put_byte(8'h99, ak); check("R8 data ack", ak, 1);
    do_start;
    put_byte(8'hAB, ak); check("R8 read select ack", ak, 1);
    get_byte(1'b0, rb);  check("R8 next location clear", rb, 0);
    do_stop;
    check("R8 no busy after abort", busy, 0);
    ebuf[0] = 8'h00;
    rd_check("R8 aborted byte absent", 8'h31, 1);

    // R9: pointer wraps 127 -> 0.
    wbuf[0] = 8'h5A;
    wr_page("R5 data ack", 8'h7F, 1);
    ebuf[0] = 8'h5A; ebuf[1] = 8'h11;
    rd_check("R9 wrap read", 8'h7F, 2);

    repeat (10) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule